// File: doc/BRIEF.md
# Deferred Gate Slope Setting Register

This block keeps the programmed charge (rising-edge) and discharge (falling-edge) current codes for a set of gate drivers. It decides in which cycle a newly written code reaches the current setting that the driver uses. This prevents a slope change from distorting an edge that is already in progress.

Once any driver has switched, a write to a rising code goes into a shadow register. It takes effect only after the next falling gate edge of that driver. A write to a falling code waits in the same way for the next rising edge. Between a wake-up (or reset) and the first switch of any driver, writes take effect at once.

Two global mode flags travel next to the codes without changing them:
- a quarter-current scale indication;
- a bypass indication for unlimited switching mode. In this mode, external gate resistors set the speed.

Top module: `gate_slope_ctrl`

## Requirements
- R1: After reset every effective rising and falling code reads 0, and `quarter_scale_o` and `limit_bypass_o` read 0.
- R2: While no driver has switched since reset or wake-up, a rising or falling code write shows on that driver's effective output at the next clock edge.
- R3: After a switch, a rising code write does not change the effective rising code. It is committed on the clock edge that samples the next falling gate edge of the same driver.
- R4: After a switch, a falling code write does not change the effective falling code. It is committed on the clock edge that samples the next rising gate edge of the same driver.
- R5: A gate edge on any driver arms deferral for every driver. Later writes to another driver are also held.
- R6: If a write arrives in the same cycle as the committing edge, the previously staged value is committed and the new value stays pending until the following committing edge.
- R7: A wake-up pulse clears the armed state and applies any pending codes. A write in the wake cycle or after it, before the next switch, applies at once.
- R8: A config write with bit 6 set to 1 raises `quarter_scale_o` on the next cycle, and a config write with bit 6 set to 0 lowers it on the next cycle. The effective codes stay unchanged.
- R9: Bit 7 of a config write sets `limit_bypass_o` on the next cycle.
- R10: An edge of the non-committing polarity leaves a pending code held. A rising edge does not commit a rising code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | One-cycle pulse on entry to active mode |
| gate_i | input | N_DRV | Gate command per driver |
| rise_wr_i | input | N_DRV | Write strobe for the rising code, per driver |
| fall_wr_i | input | N_DRV | Write strobe for the falling code, per driver |
| slope_wdata_i | input | CODE_W | Code data for slope writes (all ones = maximum current) |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 8 | Config data: bit 6 quarter current, bit 7 switching mode |
| rise_code_o | output | N_DRV*CODE_W | Effective rising codes, driver i at bits i*CODE_W |
| fall_code_o | output | N_DRV*CODE_W | Effective falling codes, driver i at bits i*CODE_W |
| quarter_scale_o | output | 1 | Currents scaled to 25 % |
| limit_bypass_o | output | 1 | Current limiting bypassed |

## Verification
The assertions check on every cycle the properties that local state can express:
- an armed channel keeps its code except on commit or wake;
- an unarmed or wake-cycle write loads directly;
- a commit loads the staged value;
- the armed flag is sticky, and wake clears it;
- config bits load on the next cycle.

Only the bench scenarios can show the cross-driver effects. These are one driver arming another's deferral, and an opposite-polarity edge leaving a code held. The same holds for the same-cycle write-and-edge ordering across several edges, and for the whole sequence from wake through a deferred commit.

// File: rtl/slope_pkg.sv
package slope_pkg;
  localparam int unsigned CODE_W         = 6;
  localparam int unsigned CFG_W          = 8;
  localparam int unsigned CFG_QUARTER_BIT = 6;
  localparam int unsigned CFG_BYPASS_BIT  = 7;
endpackage

// File: rtl/slope_edge_det.sv
module slope_edge_det #(
  parameter int unsigned N_DRV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DRV-1:0] gate_i,
  output logic [N_DRV-1:0] rise_o,
  output logic [N_DRV-1:0] fall_o,
  output logic             any_o
);
  logic [N_DRV-1:0] gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
  assign fall_o = ~gate_i & gate_q;
  assign any_o  = |(gate_i ^ gate_q);
endmodule

// File: rtl/slope_mode_reg.sv
module slope_mode_reg
  import slope_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic             edge_any_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             quarter_o,
  output logic             bypass_o,
  output logic             armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quarter_o <= 1'b0;
      bypass_o  <= 1'b0;
    end else if (cfg_wr_i) begin
      quarter_o <= cfg_wdata_i[CFG_QUARTER_BIT];
      bypass_o  <= cfg_wdata_i[CFG_BYPASS_BIT];
    end
  end

  // sticky "some driver switched since wake", shared by all drivers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_o <= 1'b0;
    else if (wake_i) armed_o <= 1'b0;
    else if (edge_any_i) armed_o <= 1'b1;
  end

  // R5
  armed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !wake_i) |=> armed_o);
  // R7
  wake_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !armed_o);
  // R8
  quarter_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> quarter_o == $past(cfg_wdata_i[CFG_QUARTER_BIT]));
  // R9
  bypass_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> bypass_o == $past(cfg_wdata_i[CFG_BYPASS_BIT]));
endmodule

// File: rtl/slope_stage.sv
module slope_stage #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wake_i,
  input  logic         armed_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] shd_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else if (wake_i) begin
      code_o <= wr_i ? wdata_i : (pend_q ? shd_q : code_o);
      if (wr_i) shd_q <= wdata_i;
      pend_q <= 1'b0;
    end else if (wr_i && !armed_i) begin
      code_o <= wdata_i;
      shd_q  <= wdata_i;
      pend_q <= 1'b0;
    end else begin
      // old staged value commits; a same-cycle write stays pending
      if (commit_i && pend_q) code_o <= shd_q;
      if (wr_i) begin
        shd_q  <= wdata_i;
        pend_q <= 1'b1;
      end else if (commit_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R3
  hold_until_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !commit_i && !wake_i) |=> $stable(code_o));
  // R2
  direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (!armed_i || wake_i)) |=> code_o == $past(wdata_i));
  // R6
  commit_staged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && armed_i && pend_q && !wake_i) |=> code_o == $past(shd_q));
  // R6
  write_on_commit_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && armed_i && wr_i && !wake_i) |=> pend_q);
endmodule

// File: rtl/gate_slope_ctrl.sv
module gate_slope_ctrl
  import slope_pkg::*;
#(
  parameter int unsigned N_DRV  = 2,
  parameter int unsigned CODE_W = slope_pkg::CODE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wake_i,
  input  logic [N_DRV-1:0]         gate_i,
  input  logic [N_DRV-1:0]         rise_wr_i,
  input  logic [N_DRV-1:0]         fall_wr_i,
  input  logic [CODE_W-1:0]        slope_wdata_i,
  input  logic                     cfg_wr_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  output logic [N_DRV*CODE_W-1:0]  rise_code_o,
  output logic [N_DRV*CODE_W-1:0]  fall_code_o,
  output logic                     quarter_scale_o,
  output logic                     limit_bypass_o
);
  logic [N_DRV-1:0] rise_edge, fall_edge;
  logic             edge_any, armed;

  slope_edge_det #(.N_DRV(N_DRV)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (rise_edge),
    .fall_o (fall_edge),
    .any_o  (edge_any)
  );

  slope_mode_reg u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_i      (wake_i),
    .edge_any_i  (edge_any),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .quarter_o   (quarter_scale_o),
    .bypass_o    (limit_bypass_o),
    .armed_o     (armed)
  );

  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    // rising code commits on falling gate edge, and vice versa
    slope_stage #(.W(CODE_W)) u_rise (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wake_i   (wake_i),
      .armed_i  (armed),
      .wr_i     (rise_wr_i[i]),
      .wdata_i  (slope_wdata_i),
      .commit_i (fall_edge[i]),
      .code_o   (rise_code_o[i*CODE_W +: CODE_W])
    );
    slope_stage #(.W(CODE_W)) u_fall (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wake_i   (wake_i),
      .armed_i  (armed),
      .wr_i     (fall_wr_i[i]),
      .wdata_i  (slope_wdata_i),
      .commit_i (rise_edge[i]),
      .code_o   (fall_code_o[i*CODE_W +: CODE_W])
    );
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rise_code_o == '0 && fall_code_o == '0 && !quarter_scale_o && !limit_bypass_o));
endmodule

// File: tb/sim_gate_slope_ctrl.sv
module sim_gate_slope_ctrl;
  localparam int N = 2;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wake = 1'b0;
  logic [N-1:0] gate = '0, rw = '0, fw = '0;
  logic [W-1:0] wdata = '0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [N*W-1:0] rise_code, fall_code;
  logic quarter, bypass;

  always #4 clk = ~clk;

  gate_slope_ctrl #(.N_DRV(N), .CODE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wake_i(wake), .gate_i(gate),
    .rise_wr_i(rw), .fall_wr_i(fw), .slope_wdata_i(wdata),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .rise_code_o(rise_code), .fall_code_o(fall_code),
    .quarter_scale_o(quarter), .limit_bypass_o(bypass)
  );

  typedef struct {
    logic [N*W-1:0] rise;
    logic [N*W-1:0] fall;
    logic           sc;
    logic           by;
    string          tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // requirement model
  logic [W-1:0] m_re[N], m_rs[N], m_fe[N], m_fs[N];
  logic         m_rp[N], m_fp[N], m_prev[N];
  logic         m_armed = 1'b0, m_sc = 1'b0, m_by = 1'b0;

  initial for (int i = 0; i < N; i++) begin
    m_re[i] = '0; m_rs[i] = '0; m_fe[i] = '0; m_fs[i] = '0;
    m_rp[i] = 1'b0; m_fp[i] = 1'b0; m_prev[i] = 1'b0;
  end

  task automatic cyc(input logic wk, input logic [N-1:0] g, input logic [N-1:0] r,
                     input logic [N-1:0] f, input logic [W-1:0] d,
                     input logic cw, input logic [7:0] cd, input string tag);
    exp_t e;
    logic any_edge;
    @(negedge clk);
    wake = wk; gate = g; rw = r; fw = f; wdata = d; cfg_wr = cw; cfg_wdata = cd;
    any_edge = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic re, fe;
      re = g[i] & ~m_prev[i];
      fe = ~g[i] & m_prev[i];
      any_edge |= re | fe;
      // rising code: commits on falling edge
      if (wk) begin
        m_re[i] = r[i] ? d : (m_rp[i] ? m_rs[i] : m_re[i]);
        if (r[i]) m_rs[i] = d;
        m_rp[i] = 1'b0;
      end else if (r[i] && !m_armed) begin
        m_re[i] = d; m_rs[i] = d; m_rp[i] = 1'b0;
      end else begin
        if (fe && m_rp[i]) m_re[i] = m_rs[i];
        if (r[i]) begin m_rs[i] = d; m_rp[i] = 1'b1; end
        else if (fe) m_rp[i] = 1'b0;
      end
      // falling code: commits on rising edge
      if (wk) begin
        m_fe[i] = f[i] ? d : (m_fp[i] ? m_fs[i] : m_fe[i]);
        if (f[i]) m_fs[i] = d;
        m_fp[i] = 1'b0;
      end else if (f[i] && !m_armed) begin
        m_fe[i] = d; m_fs[i] = d; m_fp[i] = 1'b0;
      end else begin
        if (re && m_fp[i]) m_fe[i] = m_fs[i];
        if (f[i]) begin m_fs[i] = d; m_fp[i] = 1'b1; end
        else if (re) m_fp[i] = 1'b0;
      end
      m_prev[i] = g[i];
    end
    m_armed = wk ? 1'b0 : (m_armed | any_edge);
    if (cw) begin m_sc = cd[6]; m_by = cd[7]; end
    for (int i = 0; i < N; i++) begin
      e.rise[i*W +: W] = m_re[i];
      e.fall[i*W +: W] = m_fe[i];
    end
    e.sc = m_sc; e.by = m_by; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample 2 ns after the edge that consumed the item
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rise_code !== e.rise || fall_code !== e.fall || quarter !== e.sc || bypass !== e.by) begin
        fails++;
        $display("FAIL %s: rise=%h fall=%h sc=%b by=%b expected rise=%h fall=%h sc=%b by=%b",
                 e.tag, rise_code, fall_code, quarter, bypass, e.rise, e.fall, e.sc, e.by);
      end
    end
  end

  task automatic chk_reset();
    checks++;
    if (rise_code !== '0 || fall_code !== '0 || quarter !== 1'b0 || bypass !== 1'b0) begin
      fails++;
      $display("FAIL R1: rise=%h fall=%h sc=%b by=%b expected all zero",
               rise_code, fall_code, quarter, bypass);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();            // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset();            // R1 after release

    // R2 immediate writes before any switch
    cyc(0, 2'b00, 2'b01, 2'b00, 6'h0A, 0, 8'h00, "R2 rise0 immediate");
    cyc(0, 2'b00, 2'b00, 2'b10, 6'h14, 0, 8'h00, "R2 fall1 immediate");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R2 idle");
    // R8 / R9 mode flags
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 1, 8'h40, "R8 quarter set");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 1, 8'h80, "R9 bypass set R8 quarter clear");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 1, 8'hC0, "R8 R9 both set");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 1, 8'h00, "R8 R9 both clear");
    // R3 deferral after first switch
    cyc(0, 2'b01, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R3 gate0 rises");
    cyc(0, 2'b01, 2'b01, 2'b00, 6'h15, 0, 8'h00, "R3 rise0 write held");
    cyc(0, 2'b01, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R3 still held");
    // R5 other driver deferred too
    cyc(0, 2'b01, 2'b10, 2'b00, 6'h2A, 0, 8'h00, "R5 rise1 held");
    // R10 rising edge does not commit rising code
    cyc(0, 2'b11, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R10 gate1 rises, rise1 held");
    cyc(0, 2'b10, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R3 gate0 falls, rise0 commits");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R5 gate1 falls, rise1 commits");
    // R4 / R6 falling code with same-cycle write
    cyc(0, 2'b00, 2'b00, 2'b01, 6'h11, 0, 8'h00, "R4 fall0 write held");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R4 still held");
    cyc(0, 2'b01, 2'b00, 2'b01, 6'h22, 0, 8'h00, "R6 edge+write commits old");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R10 falling edge no fall commit");
    cyc(0, 2'b01, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R4 rise commits new fall0");
    cyc(0, 2'b00, 2'b00, 2'b01, 6'h3F, 0, 8'h00, "R4 max code held");
    // R7 wake applies pending and re-enables immediate writes
    cyc(0, 2'b00, 2'b01, 2'b00, 6'h33, 0, 8'h00, "R7 rise0 pending");
    cyc(1, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R7 wake applies pending");
    cyc(0, 2'b00, 2'b00, 2'b01, 6'h05, 0, 8'h00, "R7 immediate after wake");
    cyc(1, 2'b00, 2'b10, 2'b00, 6'h07, 0, 8'h00, "R7 write in wake cycle");
    cyc(0, 2'b10, 2'b10, 2'b00, 6'h09, 0, 8'h00, "R2 write in first-switch cycle");
    cyc(0, 2'b10, 2'b10, 2'b00, 6'h0C, 0, 8'h00, "R5 held after switch");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R3 gate1 falls commits");
    cyc(0, 2'b00, 2'b00, 2'b00, 6'h00, 0, 8'h00, "R3 idle");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule